// File: doc/BRIEF.md
# Inter-Processor Interrupt and Mailbox Controller

This block lets each processor core in a small cluster interrupt any other core and leave 32-bit message words for it. Every core owns an access port into its own private register window. In that window it can read its pending-interrupt status, program an interrupt enable mask, acknowledge interrupts through a write-one-to-clear register, and read eight 32-bit mailbox words. The eight words form four 64-bit mailboxes.

A core reaches another core through two send registers in its own window. An interrupt send names a target core and a vector number, and sets that vector's status bit at the target. A mailbox send is a single 64-bit command. It names a target core and a mailbox word, carries a 32-bit payload, and holds a four-bit byte-keep mask. A set bit in that mask preserves the byte already stored at the destination. Each core has one interrupt output: the OR of its enabled pending status bits.

All cores may issue accesses in the same cycle. Register updates take effect at the clock edge that accepts the write. Read data returns one cycle after the read request.

Top module: `ipi_mailbox_ctrl`

## Requirements
- R1: After reset, every status, enable and mailbox register reads zero and every interrupt output is low.
- R2: A write to window offset 0x40 is an interrupt send. Bits 4:0 are the vector and bits 25:16 are the target core. The write sets status bit `vector` of the target core at that edge, and the status register at offset 0x00 shows the bit.
- R3: The enable register at offset 0x04 is read/write. A core's interrupt output is high exactly when some status bit and the matching enable bit are both set.
- R4: A write to offset 0x08 clears each status bit whose data bit is 1 and leaves the other status bits unchanged. This register reads as zero.
- R5: When an interrupt send sets a status bit in the same cycle that the owning core clears it, the bit ends up set.
- R6: A full 64-bit write to offset 0x48 is a mailbox send. Bits 25:16 are the target core and bits 4:2 are the word index w. Bits 63:32 are the payload, which goes to the target's word at offset 0x20 + 4*w. With mask bits 30:27 all zero, the whole word is replaced.
- R7: In a mailbox send, destination byte i keeps its previous value when command bit 27+i is 1 and takes payload byte i when that bit is 0.
- R8: A 32-bit write to offset 0x48 has no effect on any mailbox.
- R9: A send whose target field is 4 or greater (the default core count) changes no status and no mailbox anywhere, including targets whose low bits alias a real core.
- R10: Interrupt sends from several cores in one cycle all take effect. When several mailbox sends hit the same word in one cycle, the lowest-numbered sending core's command is applied.
- R11: A read returns its data on the cycle after the request. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_CORES | Per-core access request |
| req_write | input | NUM_CORES | Per-core write (1) or read (0) |
| req_wide | input | NUM_CORES | Per-core access size: 1 for 64-bit, 0 for 32-bit |
| req_addr | input | NUM_CORES*ADDR_W | Per-core byte offset within the core's own window |
| req_wdata | input | NUM_CORES*64 | Per-core write data |
| rsp_rdata | output | NUM_CORES*32 | Per-core read data, valid the cycle after a read |
| irq_o | output | NUM_CORES | Per-core interrupt output |

## Verification
The bench builds the block with its default parameters: four cores and an 8-bit window offset. These settings reach both extreme vectors (0 and 31), the top mailbox word (index 7), and target fields of 4 and 1023. The value 1023 aliases core 3 in its low bits, so any truncated range check would show up. With four separate access ports, the bench can drive a clear and a send into the same status bit in one cycle. It can also drive two mailbox sends into the same word in one cycle, which reaches the set-wins and lowest-sender-wins orderings.

// File: rtl/ipi_mbx_pkg.sv
package ipi_mbx_pkg;

    localparam int TGT_W   = 10;
    localparam int VEC_W   = 5;
    localparam int STAT_W  = 1 << VEC_W;
    localparam int WIDX_W  = 3;
    localparam int NWORDS  = 1 << WIDX_W;
    localparam int LANES   = 4;

    localparam int OFF_STATUS    = 'h00;
    localparam int OFF_ENABLE    = 'h04;
    localparam int OFF_CLEAR     = 'h08;
    localparam int OFF_MBX_BASE  = 'h20;
    localparam int OFF_IRQ_SEND  = 'h40;
    localparam int OFF_MAIL_SEND = 'h48;

    typedef enum logic [1:0] {
        RD_NONE,
        RD_STATUS,
        RD_ENABLE,
        RD_MBX
    } rd_sel_e;

    typedef struct packed {
        logic              irq_v;
        logic              mbx_v;
        logic [TGT_W-1:0]  tgt;
        logic [VEC_W-1:0]  vec;
        logic [WIDX_W-1:0] word;
        logic [LANES-1:0]  keep;
        logic [31:0]       data;
    } send_t;

    typedef struct packed {
        logic              en_we;
        logic              clr_we;
        logic [31:0]       wval;
        rd_sel_e           rd_sel;
        logic [WIDX_W-1:0] rd_word;
    } local_t;

    function automatic logic [31:0] merge_lanes(input logic [31:0] old_w,
                                                input logic [31:0] new_w,
                                                input logic [LANES-1:0] keep);
        logic [31:0] r;
        for (int i = 0; i < LANES; i++) begin
            r[i*8 +: 8] = keep[i] ? old_w[i*8 +: 8] : new_w[i*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/ipi_send_decode.sv
module ipi_send_decode
    import ipi_mbx_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 8
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    output send_t             snd_o,
    output local_t            loc_o
);

    localparam logic [TGT_W-1:0] TGT_LIMIT = TGT_W'(NUM_CORES);

    logic             wr_acc;
    logic             rd_acc;
    logic [TGT_W-1:0] tgt_field;
    logic             tgt_ok;
    logic             is_mbx_addr;

    assign wr_acc      = req_valid && req_write;
    assign rd_acc      = req_valid && !req_write;
    assign tgt_field   = req_wdata[25:16];
    assign tgt_ok      = tgt_field < TGT_LIMIT;
    assign is_mbx_addr = (req_addr >= ADDR_W'(OFF_MBX_BASE)) &&
                         (req_addr <  ADDR_W'(OFF_MBX_BASE + 4 * NWORDS)) &&
                         (req_addr[1:0] == 2'b00);

    always_comb begin
        snd_o       = '0;
        snd_o.tgt   = tgt_field;
        snd_o.vec   = req_wdata[VEC_W-1:0];
        snd_o.word  = req_wdata[2 +: WIDX_W];
        snd_o.keep  = req_wdata[27 +: LANES];
        snd_o.data  = req_wdata[63:32];
        snd_o.irq_v = wr_acc && tgt_ok && (req_addr == ADDR_W'(OFF_IRQ_SEND));
        snd_o.mbx_v = wr_acc && tgt_ok && req_wide &&
                      (req_addr == ADDR_W'(OFF_MAIL_SEND));
    end

    always_comb begin
        loc_o         = '0;
        loc_o.wval    = req_wdata[31:0];
        loc_o.en_we   = wr_acc && (req_addr == ADDR_W'(OFF_ENABLE));
        loc_o.clr_we  = wr_acc && (req_addr == ADDR_W'(OFF_CLEAR));
        loc_o.rd_word = req_addr[2 +: WIDX_W];
        loc_o.rd_sel  = RD_NONE;
        if (rd_acc) begin
            if (req_addr == ADDR_W'(OFF_STATUS))      loc_o.rd_sel = RD_STATUS;
            else if (req_addr == ADDR_W'(OFF_ENABLE)) loc_o.rd_sel = RD_ENABLE;
            else if (is_mbx_addr)                     loc_o.rd_sel = RD_MBX;
        end
    end

endmodule

// File: rtl/ipi_core_regs.sv
module ipi_core_regs
    import ipi_mbx_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CORE_IDX  = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  send_t [NUM_CORES-1:0] sends_i,
    input  local_t                loc_i,
    output logic [31:0]           rdata_o,
    output logic                  irq_o
);

    localparam logic [TGT_W-1:0] ME = TGT_W'(CORE_IDX);

    logic [STAT_W-1:0] status_q, enable_q, set_mask, clr_mask;
    logic [31:0]       mbx_q   [NWORDS];
    logic [31:0]       mbx_new [NWORDS];
    logic [LANES-1:0]  mbx_keep[NWORDS];
    logic [NWORDS-1:0] wr_hit;

    always_comb begin
        set_mask = '0;
        for (int s = 0; s < NUM_CORES; s++) begin
            if (sends_i[s].irq_v && sends_i[s].tgt == ME)
                set_mask = set_mask | (STAT_W'(1) << sends_i[s].vec);
        end
        clr_mask = loc_i.clr_we ? loc_i.wval[STAT_W-1:0] : '0;
    end

    always_comb begin
        for (int w = 0; w < NWORDS; w++) begin
            wr_hit[w]   = 1'b0;
            mbx_new[w]  = '0;
            mbx_keep[w] = '0;
            for (int s = NUM_CORES - 1; s >= 0; s--) begin
                if (sends_i[s].mbx_v && sends_i[s].tgt == ME &&
                    sends_i[s].word == WIDX_W'(w)) begin
                    wr_hit[w]   = 1'b1;
                    mbx_new[w]  = sends_i[s].data;
                    mbx_keep[w] = sends_i[s].keep;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_mask) | set_mask;
            if (loc_i.en_we) enable_q <= loc_i.wval[STAT_W-1:0];
        end
    end

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                mbx_q[w] <= '0;
            end else if (wr_hit[w]) begin
                mbx_q[w] <= merge_lanes(mbx_q[w], mbx_new[w], mbx_keep[w]);
            end
        end

        AST_MBX_HOLD: assert property (@(posedge clk) disable iff (rst)
            !wr_hit[w] |=> $stable(mbx_q[w])); // R6
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o <= '0;
        end else begin
            unique case (loc_i.rd_sel)
                RD_STATUS: rdata_o <= 32'(status_q);
                RD_ENABLE: rdata_o <= 32'(enable_q);
                RD_MBX:    rdata_o <= mbx_q[loc_i.rd_word];
                default:   rdata_o <= '0;
            endcase
        end
    end

    assign irq_o = |(status_q & enable_q);

    AST_SET_NEEDS_SEND: assert property (@(posedge clk) disable iff (rst)
        (|(status_q & ~$past(status_q))) |-> $past(|set_mask)); // R2

    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> ($past(|set_mask) || $past(loc_i.en_we))); // R3

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        loc_i.clr_we |=> ((status_q & $past(clr_mask & ~set_mask)) == '0)); // R4

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|set_mask) |=> ((status_q & $past(set_mask)) == $past(set_mask))); // R5

endmodule

// File: rtl/ipi_mailbox_ctrl.sv
module ipi_mailbox_ctrl
    import ipi_mbx_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_CORES-1:0]        req_valid,
    input  logic [NUM_CORES-1:0]        req_write,
    input  logic [NUM_CORES-1:0]        req_wide,
    input  logic [NUM_CORES*ADDR_W-1:0] req_addr,
    input  logic [NUM_CORES*64-1:0]     req_wdata,
    output logic [NUM_CORES*32-1:0]     rsp_rdata,
    output logic [NUM_CORES-1:0]        irq_o
);

    send_t  [NUM_CORES-1:0] sends;
    local_t [NUM_CORES-1:0] locs;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        ipi_send_decode #(
            .NUM_CORES (NUM_CORES),
            .ADDR_W    (ADDR_W)
        ) u_dec (
            .req_valid (req_valid[c]),
            .req_write (req_write[c]),
            .req_wide  (req_wide[c]),
            .req_addr  (req_addr[c*ADDR_W +: ADDR_W]),
            .req_wdata (req_wdata[c*64 +: 64]),
            .snd_o     (sends[c]),
            .loc_o     (locs[c])
        );

        ipi_core_regs #(
            .NUM_CORES (NUM_CORES),
            .CORE_IDX  (c)
        ) u_regs (
            .clk     (clk),
            .rst     (rst),
            .sends_i (sends),
            .loc_i   (locs[c]),
            .rdata_o (rsp_rdata[c*32 +: 32]),
            .irq_o   (irq_o[c])
        );
    end

endmodule

// File: tb/sim_ipi_mailbox_ctrl.sv
`timescale 1ns/1ps
module sim_ipi_mailbox_ctrl;

    localparam int NC = 4;
    localparam int AW = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NC-1:0]     req_valid = '0, req_write = '0, req_wide = '0;
    logic [NC*AW-1:0]  req_addr  = '0;
    logic [NC*64-1:0]  req_wdata = '0;
    logic [NC*32-1:0]  rsp_rdata;
    logic [NC-1:0]     irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] mbx_m [NC][8];

    always #2.5 clk = ~clk;

    ipi_mailbox_ctrl #(.NUM_CORES(NC), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .irq_o(irq_o)
    );

    function automatic logic [31:0] mk_irq(input logic [9:0] tgt, input logic [4:0] vec);
        return {6'b0, tgt, 11'b0, vec};
    endfunction

    function automatic logic [63:0] mk_mail(input logic [31:0] d, input logic [3:0] keep,
                                            input logic [9:0] tgt, input logic [2:0] w);
        return {d, 1'b0, keep, 1'b0, tgt, 11'b0, w, 2'b00};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input int s, input bit wr, input bit wide,
                         input logic [7:0] a, input logic [63:0] d);
        req_valid[s]          = 1'b1;
        req_write[s]          = wr;
        req_wide[s]           = wide;
        req_addr[s*AW +: AW]  = a;
        req_wdata[s*64 +: 64] = d;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        req_valid = '0;
        req_write = '0;
        req_wide  = '0;
    endtask

    task automatic rd(input int s, input logic [7:0] a, output logic [31:0] v);
        drive(s, 1'b0, 1'b0, a, 64'h0);
        step();
        v = rsp_rdata[s*32 +: 32];
    endtask

    task automatic wr32(input int s, input logic [7:0] a, input logic [31:0] d);
        drive(s, 1'b1, 1'b0, a, {32'h0, d});
        step();
    endtask

    task automatic wr64(input int s, input logic [7:0] a, input logic [63:0] d);
        drive(s, 1'b1, 1'b1, a, d);
        step();
    endtask

    task automatic check_all_mbx(input string req);
        logic [31:0] v;
        for (int c = 0; c < NC; c++)
            for (int w = 0; w < 8; w++) begin
                rd(c, 8'(8'h20 + 4 * w), v);
                check(req, v, mbx_m[c][w]);
            end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int c = 0; c < NC; c++) begin
            rd(c, 8'h00, v); check("R1 status", v, 0);
            rd(c, 8'h04, v); check("R1 enable", v, 0);
        end
        check("R1 irq", irq_o, 0);
        check_all_mbx("R1 mailbox");
    endtask

    task automatic t_irq_send();
        logic [31:0] v;
        wr32(0, 8'h40, mk_irq(10'd3, 5'd5));
        rd(3, 8'h00, v); check("R2 status core3", v, 32'h20);
        check("R3 irq masked", irq_o, 0);
        wr32(1, 8'h40, mk_irq(10'd0, 5'd31));
        rd(0, 8'h00, v); check("R2 vector31 core0", v, 32'h8000_0000);
        rd(1, 8'h00, v); check("R2 other core untouched", v, 0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr32(3, 8'h04, 32'h0000_0020);
        check("R3 irq raised", irq_o, 4'b1000);
        rd(3, 8'h04, v); check("R3 enable readback", v, 32'h20);
        wr32(3, 8'h04, 32'h0000_0040);
        check("R3 irq follows enable", irq_o, 4'b0000);
        wr32(3, 8'h04, 32'hFFFF_FFFF);
        check("R3 irq re-enabled", irq_o, 4'b1000);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr32(2, 8'h40, mk_irq(10'd3, 5'd9));
        wr32(3, 8'h08, 32'h0000_0020);
        rd(3, 8'h00, v); check("R4 partial clear", v, 32'h200);
        check("R4 irq still up", irq_o, 4'b1000);
        wr32(3, 8'h08, 32'h0000_0200);
        rd(3, 8'h00, v); check("R4 all cleared", v, 0);
        check("R4 irq dropped", irq_o, 4'b0000);
        rd(3, 8'h08, v); check("R4 clear reads zero", v, 0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        wr32(0, 8'h40, mk_irq(10'd2, 5'd3));
        drive(1, 1'b1, 1'b0, 8'h40, {32'h0, mk_irq(10'd2, 5'd3)});
        drive(2, 1'b1, 1'b0, 8'h08, 64'h0000_0000_0000_0008);
        step();
        rd(2, 8'h00, v); check("R5 set beats clear", v, 32'h8);
        wr32(2, 8'h08, 32'h8);
    endtask

    task automatic t_mail_full();
        logic [31:0] v;
        wr64(1, 8'h48, mk_mail(32'h1122_3344, 4'b0000, 10'd0, 3'd5));
        mbx_m[0][5] = 32'h1122_3344;
        rd(0, 8'h34, v); check("R6 full word", v, 32'h1122_3344);
        wr64(0, 8'h48, mk_mail(32'hCAFE_0007, 4'b0000, 10'd3, 3'd7));
        mbx_m[3][7] = 32'hCAFE_0007;
        rd(3, 8'h3C, v); check("R6 top word", v, 32'hCAFE_0007);
        rd(3, 8'h38, v); check("R6 neighbour untouched", v, 0);
    endtask

    task automatic t_mail_mask();
        logic [31:0] v;
        wr64(2, 8'h48, mk_mail(32'hFFEE_DDCC, 4'b0101, 10'd0, 3'd5));
        mbx_m[0][5] = 32'hFF22_DD44;
        rd(0, 8'h34, v); check("R7 byte keep", v, 32'hFF22_DD44);
        wr64(2, 8'h48, mk_mail(32'h0000_0000, 4'b1111, 10'd0, 3'd5));
        rd(0, 8'h34, v); check("R7 keep all", v, 32'hFF22_DD44);
    endtask

    task automatic t_narrow();
        logic [31:0] v;
        drive(1, 1'b1, 1'b0, 8'h48, mk_mail(32'hDEAD_BEEF, 4'b0000, 10'd0, 3'd5));
        step();
        rd(0, 8'h34, v); check("R8 narrow ignored", v, 32'hFF22_DD44);
        check_all_mbx("R8 no mailbox change");
    endtask

    task automatic t_bad_target();
        logic [31:0] v;
        wr32(0, 8'h40, mk_irq(10'd4, 5'd1));
        wr32(0, 8'h40, mk_irq(10'h3FF, 5'd2));
        wr64(1, 8'h48, mk_mail(32'h5555_AAAA, 4'b0000, 10'd4, 3'd0));
        wr64(1, 8'h48, mk_mail(32'h5555_AAAA, 4'b0000, 10'h3FF, 3'd7));
        for (int c = 0; c < NC; c++) begin
            rd(c, 8'h00, v);
            check("R9 status unchanged", v, (c == 0) ? 32'h8000_0000 : 32'h0);
        end
        check_all_mbx("R9 mailbox unchanged");
    endtask

    task automatic t_concurrent();
        logic [31:0] v;
        drive(0, 1'b1, 1'b0, 8'h40, {32'h0, mk_irq(10'd1, 5'd0)});
        drive(2, 1'b1, 1'b0, 8'h40, {32'h0, mk_irq(10'd1, 5'd31)});
        step();
        rd(1, 8'h00, v); check("R10 both vectors", v, 32'h8000_0001);
        drive(1, 1'b1, 1'b1, 8'h48, mk_mail(32'h1111_0001, 4'b0000, 10'd2, 3'd7));
        drive(3, 1'b1, 1'b1, 8'h48, mk_mail(32'h3333_0003, 4'b0000, 10'd2, 3'd7));
        step();
        mbx_m[2][7] = 32'h1111_0001;
        rd(2, 8'h3C, v); check("R10 lowest sender wins", v, 32'h1111_0001);
    endtask

    task automatic t_read_path();
        logic [31:0] v;
        rd(0, 8'h10, v); check("R11 unmapped zero", v, 0);
        rd(0, 8'h4C, v); check("R11 beyond window zero", v, 0);
        drive(3, 1'b0, 1'b0, 8'h3C, 64'h0);
        @(posedge clk);
        #1;
        check("R11 data after one cycle", rsp_rdata[3*32 +: 32], mbx_m[3][7]);
        @(negedge clk);
        req_valid = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++)
            for (int w = 0; w < 8; w++) mbx_m[c][w] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_irq_send();
        t_enable();
        t_clear();
        t_set_wins();
        t_mail_full();
        t_mail_mask();
        t_narrow();
        t_bad_target();
        t_concurrent();
        t_read_path();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule